// File: doc/BRIEF.md
# Predicated Saturating Doubling Widening Multiplier

This block is one registered stage of a vector datapath. It receives two 128-bit source vectors packed with narrow signed elements (16 or 32 bits wide), the previous contents of the destination vector, and a 16-bit predicate with one bit per destination byte. Each destination lane is twice as wide as a source element. For each lane the block takes either the even or the odd element of each adjacent pair from both sources. It forms the doubled product of the two elements at full width, clamps the one overflowing case, and writes the lane into the destination.

Destination bytes whose predicate bit is clear keep their old value. The block keeps a sticky saturation flag, which only a lane with an active predicate can set. Software clears the flag through an explicit input. The block also flags two kinds of illegal request: a reserved element size, and a 32-bit-source operation whose destination register index equals one of its source register indices. An illegal request writes nothing.

Top module: `sdw_mul_top`

## Requirements
- R1: `size_sel` encoding: 2'b01 selects 16-bit sources with four 32-bit lanes, and 2'b10 selects 32-bit sources with two 64-bit lanes. The values 2'b00 and 2'b11 are illegal. An illegal request gives `illegal`=1 and `res_vec` equal to `dst_old`, and it leaves `sat_sticky` unchanged.
- R2: Narrow element k of a source occupies bits [k*NW +: NW]. Lane i takes element 2*i from each source when `top_sel`=0 and element 2*i+1 when `top_sel`=1. Lane i is written to bits [i*2*NW +: 2*NW] of `res_vec`, so lane 0 is least significant.
- R3: Each lane value is 2*a*b for signed a and b, computed at the double width.
- R4: When both a and b equal the most negative narrow value, the lane value saturates to the largest positive double-width value. No other operand pair saturates.
- R5: Byte j of `res_vec` takes the new lane data when `pred[j]`=1 and keeps byte j of `dst_old` when `pred[j]`=0.
- R6: `sat_sticky` becomes 1 after a legal request in which some lane saturates and at least one predicate bit of that lane's byte slice is 1. A saturating lane whose predicate slice is all zero does not set it.
- R7: `sat_sticky` keeps its value until `sat_clr` is 1 at a clock edge. At that edge it clears, unless a saturation event from R6 occurs in the same cycle, in which case it stays 1.
- R8: With `size_sel`=2'b10, a `dst_idx` equal to `src_a_idx` or `src_b_idx` is illegal and is handled as in R1. With `size_sel`=2'b01 the same equality is legal.
- R9: Outputs are registered. `res_valid` is 1 in the cycle after a cycle with `op_valid`=1. When `op_valid`=0, `res_vec` and `illegal` hold their values. Reset sets every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| size_sel | input | 2 | Source element size code (R1) |
| top_sel | input | 1 | 0 = even elements, 1 = odd elements |
| vec_a | input | 128 | First source vector |
| vec_b | input | 128 | Second source vector |
| dst_old | input | 128 | Previous destination contents |
| pred | input | 16 | Per-byte write predicate |
| dst_idx | input | 3 | Destination register index |
| src_a_idx | input | 3 | First source register index |
| src_b_idx | input | 3 | Second source register index |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| res_vec | output | 128 | Merged destination vector |
| res_valid | output | 1 | Result registered this cycle |
| illegal | output | 1 | Last request was rejected |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The sweep covers all four size codes with both element halves. Operands are drawn in four ways: random values, every element at the most negative value, a mix of minimum, maximum, zero and random values, and one source pinned to the minimum. The mixes separate a correct clamp from an incorrect one, and they catch a swap between even and odd elements or a wrong lane position. The predicates used are all-zero, all-one and random. These separate byte-wise merging from lane-wise merging, and a saturating lane that is masked from one that is active. Directed cases apply register-index overlap at both sizes, set and clear the flag in the same cycle, and leave idle cycles between requests.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int VEC_BITS = 128;
    localparam int IDX_BITS = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } elem_size_e;

    typedef struct packed {
        logic [VEC_BITS-1:0] data;
        logic                sat_hit;
    } lane_bundle_t;

    function automatic logic size_legal(elem_size_e s);
        return (s == SZ_HALF) || (s == SZ_WORD);
    endfunction

endpackage

// File: rtl/sdw_lane.sv
module sdw_lane #(
    parameter int NW = 16
) (
    input  logic [NW-1:0]   op_a,
    input  logic [NW-1:0]   op_b,
    output logic [2*NW-1:0] wide,
    output logic            sat
);
    localparam int WW = 2 * NW;
    localparam logic [NW-1:0] MOST_NEG = {1'b1, {(NW-1){1'b0}}};
    localparam logic [WW-1:0] WIDE_MAX = {1'b0, {(WW-1){1'b1}}};

    logic signed [WW-1:0] ext_a, ext_b, prod;

    always_comb begin
        ext_a = {{NW{op_a[NW-1]}}, op_a};
        ext_b = {{NW{op_b[NW-1]}}, op_b};
        prod  = ext_a * ext_b;
        sat   = (op_a == MOST_NEG) && (op_b == MOST_NEG);
        wide  = sat ? WIDE_MAX : {prod[WW-2:0], 1'b0};
    end
endmodule

// File: rtl/sdw_group.sv
module sdw_group #(
    parameter int VEC_W = 128,
    parameter int NW    = 16
) (
    input  logic [VEC_W-1:0]   vec_a,
    input  logic [VEC_W-1:0]   vec_b,
    input  logic               top_sel,
    input  logic [VEC_W/8-1:0] pred,
    output sdw_pkg::lane_bundle_t out
);
    localparam int WW    = 2 * NW;
    localparam int LANES = VEC_W / WW;
    localparam int LB    = WW / 8;

    logic [LANES-1:0] lane_sat;
    logic [LANES-1:0] lane_act;
    logic [VEC_W-1:0] wide_all;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [NW-1:0] ea, eb;
        assign ea = top_sel ? vec_a[(2*i+1)*NW +: NW] : vec_a[(2*i)*NW +: NW];
        assign eb = top_sel ? vec_b[(2*i+1)*NW +: NW] : vec_b[(2*i)*NW +: NW];
        assign lane_act[i] = |pred[i*LB +: LB];

        sdw_lane #(.NW(NW)) u_lane (
            .op_a (ea),
            .op_b (eb),
            .wide (wide_all[i*WW +: WW]),
            .sat  (lane_sat[i])
        );
    end

    assign out.data    = wide_all;
    assign out.sat_hit = |(lane_sat & lane_act);
endmodule

// File: rtl/sdw_merge.sv
module sdw_merge #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]   fresh,
    input  logic [VEC_W-1:0]   old,
    input  logic [VEC_W/8-1:0] pred,
    output logic [VEC_W-1:0]   merged
);
    for (genvar j = 0; j < VEC_W/8; j++) begin : g_byte
        assign merged[j*8 +: 8] = pred[j] ? fresh[j*8 +: 8] : old[j*8 +: 8];
    end
endmodule

// File: rtl/sdw_mul_top.sv
module sdw_mul_top
    import sdw_pkg::*;
#(
    parameter int VEC_W = VEC_BITS,
    parameter int IDX_W = IDX_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [1:0]         size_sel,
    input  logic               top_sel,
    input  logic [VEC_W-1:0]   vec_a,
    input  logic [VEC_W-1:0]   vec_b,
    input  logic [VEC_W-1:0]   dst_old,
    input  logic [VEC_W/8-1:0] pred,
    input  logic [IDX_W-1:0]   dst_idx,
    input  logic [IDX_W-1:0]   src_a_idx,
    input  logic [IDX_W-1:0]   src_b_idx,
    input  logic               sat_clr,
    output logic [VEC_W-1:0]   res_vec,
    output logic               res_valid,
    output logic               illegal,
    output logic               sat_sticky
);
    localparam int PW = VEC_W / 8;

    elem_size_e   sz;
    lane_bundle_t grp16, grp32, chosen;
    logic         overlap, reject;
    logic [VEC_W-1:0] merged;

    assign sz      = elem_size_e'(size_sel);
    assign overlap = (sz == SZ_WORD) && ((dst_idx == src_a_idx) || (dst_idx == src_b_idx));
    assign reject  = !size_legal(sz) || overlap;
    assign chosen  = (sz == SZ_WORD) ? grp32 : grp16;

    sdw_group #(.VEC_W(VEC_W), .NW(16)) u_g16 (
        .vec_a(vec_a), .vec_b(vec_b), .top_sel(top_sel), .pred(pred), .out(grp16)
    );
    sdw_group #(.VEC_W(VEC_W), .NW(32)) u_g32 (
        .vec_a(vec_a), .vec_b(vec_b), .top_sel(top_sel), .pred(pred), .out(grp32)
    );
    sdw_merge #(.VEC_W(VEC_W)) u_merge (
        .fresh(chosen.data), .old(dst_old), .pred(pred), .merged(merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vec    <= '0;
            res_valid  <= 1'b0;
            illegal    <= 1'b0;
            sat_sticky <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                illegal <= reject;
                res_vec <= reject ? dst_old : merged;
            end
            sat_sticky <= (sat_sticky & ~sat_clr) | (op_valid & ~reject & chosen.sat_hit);
        end
    end

    p_bad_size_r1: assert property (@(posedge clk) disable iff (rst)
        op_valid && (size_sel == 2'b00 || size_sel == 2'b11)
        |=> illegal && res_vec == $past(dst_old));

    p_masked_keep_r5: assert property (@(posedge clk) disable iff (rst)
        op_valid && pred == '0 |=> res_vec == $past(dst_old));

    p_set_needs_active_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_sticky) |-> $past(op_valid) && $past(pred) != '0);

    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
        sat_sticky && !sat_clr |=> sat_sticky);

    p_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        op_valid && size_sel == 2'b10 && (dst_idx == src_a_idx || dst_idx == src_b_idx)
        |=> illegal && res_vec == $past(dst_old));

    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid && $stable(res_vec));

    initial assert (PW * 8 == VEC_W);
endmodule

// File: tb/tb_sdw_mul_top.sv
module tb_sdw_mul_top;
    logic clk = 0, rst = 1;
    logic op_valid = 0, top_sel = 0, sat_clr = 0;
    logic [1:0] size_sel = 0;
    logic [127:0] vec_a = 0, vec_b = 0, dst_old = 0;
    logic [15:0] pred = 0;
    logic [2:0] dst_idx = 0, src_a_idx = 1, src_b_idx = 2;
    logic [127:0] res_vec;
    logic res_valid, illegal, sat_sticky;

    int n_chk = 0, n_fail = 0;
    logic [127:0] exp_vec = 0;
    logic exp_ill = 0, exp_st = 0;

    always #2 clk = ~clk;

    sdw_mul_top dut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic void model(input logic [1:0] sz, input logic tp,
                                  input logic [127:0] a, input logic [127:0] b,
                                  input logic [127:0] old, input logic [15:0] pm,
                                  output logic [127:0] r, output logic hit);
        logic [127:0] fresh;
        fresh = '0;
        hit = 0;
        if (sz == 2'b01) begin
            for (int i = 0; i < 4; i++) begin
                logic signed [15:0] x, y;
                longint p;
                x = a[(2*i+tp)*16 +: 16];
                y = b[(2*i+tp)*16 +: 16];
                p = longint'(x) * longint'(y);
                if (x == -16'sd32768 && y == -16'sd32768) begin
                    fresh[i*32 +: 32] = 32'h7fff_ffff;
                    if (|pm[i*4 +: 4]) hit = 1;
                end else fresh[i*32 +: 32] = 32'(2 * p);
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                logic signed [31:0] x, y;
                longint p;
                x = a[(2*i+tp)*32 +: 32];
                y = b[(2*i+tp)*32 +: 32];
                p = longint'(x) * longint'(y);
                if (x == 32'sh8000_0000 && y == 32'sh8000_0000) begin
                    fresh[i*64 +: 64] = 64'h7fff_ffff_ffff_ffff;
                    if (|pm[i*8 +: 8]) hit = 1;
                end else fresh[i*64 +: 64] = 64'(p * 2);
            end
        end
        for (int j = 0; j < 16; j++) r[j*8 +: 8] = pm[j] ? fresh[j*8 +: 8] : old[j*8 +: 8];
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic tp, input logic [127:0] a,
                          input logic [127:0] b, input logic [127:0] old, input logic [15:0] pm,
                          input logic [2:0] di, input logic [2:0] ai, input logic [2:0] bi,
                          input logic clr, input string tag);
        logic [127:0] r;
        logic hit, bad;
        @(negedge clk);
        op_valid = 1; size_sel = sz; top_sel = tp; vec_a = a; vec_b = b; dst_old = old;
        pred = pm; dst_idx = di; src_a_idx = ai; src_b_idx = bi; sat_clr = clr;
        model(sz, tp, a, b, old, pm, r, hit);
        bad = (sz == 2'b00) || (sz == 2'b11) || (sz == 2'b10 && (di == ai || di == bi));
        exp_ill = bad;
        exp_vec = bad ? old : r;
        exp_st  = (exp_st & ~clr) | (~bad & hit);
        @(posedge clk); #1;
        op_valid = 0; sat_clr = 0;
        chk(res_vec === exp_vec, {tag, " R2 R3 R4 R5 data"}, res_vec, exp_vec);
        chk(illegal === exp_ill, {tag, " R1 R8 illegal"}, 128'(illegal), 128'(exp_ill));
        chk(res_valid === 1'b1, "R9 valid", 128'(res_valid), 128'd1);
        chk(sat_stickY_ok(), {tag, " R6 R7 sticky"}, 128'(sat_sticky), 128'(exp_st));
    endtask

    function automatic bit sat_stickY_ok();
        return sat_sticky === exp_st;
    endfunction

    function automatic logic [127:0] gen_vec(input logic [1:0] sz, input int mode);
        logic [127:0] v;
        for (int k = 0; k < 4; k++) v[k*32 +: 32] = $urandom;
        if (mode == 1) v = (sz == 2'b10) ? {4{32'h8000_0000}} : {8{16'h8000}};
        if (mode == 2) begin
            for (int k = 0; k < 8; k++) begin
                case ($urandom % 4)
                    0: v[k*16 +: 16] = 16'h8000;
                    1: v[k*16 +: 16] = 16'h7fff;
                    2: v[k*16 +: 16] = 16'h0000;
                    default: ;
                endcase
                if (sz == 2'b10 && k % 2 == 1 && ($urandom % 2 == 0))
                    v[(k-1)*16 +: 32] = 32'h8000_0000;
            end
        end
        return v;
    endfunction

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        chk(res_vec === 0 && res_valid === 0 && illegal === 0 && sat_stickY_ok(),
            "R9 reset", res_vec, 128'd0);

        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 2; t++)
                for (int it = 0; it < 30; it++) begin
                    logic [127:0] a, b;
                    logic [15:0] pm;
                    a = gen_vec(2'(s), it % 4 == 3 ? 1 : it % 4);
                    b = gen_vec(2'(s), it % 4 == 3 ? 2 : it % 4);
                    pm = (it % 5 == 0) ? 16'h0000 : (it % 5 == 1) ? 16'hffff : 16'($urandom);
                    run_op(2'(s), t[0], a, b, {$urandom, $urandom, $urandom, $urandom}, pm,
                           3'd0, 3'd1, 3'd2, (it % 7 == 6), "sweep");
                end

        // R8: overlap at 32-bit sources is rejected, at 16-bit it is legal
        run_op(2'b10, 0, gen_vec(2'b10, 0), gen_vec(2'b10, 0), 128'hA5, 16'hffff, 3'd4, 3'd4, 3'd2, 0, "R8 dst=a");
        run_op(2'b10, 1, gen_vec(2'b10, 1), gen_vec(2'b10, 1), 128'h5A, 16'hffff, 3'd3, 3'd1, 3'd3, 0, "R8 dst=b");
        run_op(2'b01, 0, gen_vec(2'b01, 0), gen_vec(2'b01, 0), 128'h77, 16'hffff, 3'd5, 3'd5, 3'd5, 0, "R8 half ok");

        // R6: saturation only in a masked lane does not set the flag
        run_op(2'b01, 0, 128'h0, 128'h0, 128'h0, 16'h0000, 3'd0, 3'd1, 3'd2, 1, "R7 clear");
        run_op(2'b01, 0, {112'h0, 16'h8000}, {112'h0, 16'h8000}, 128'h0, 16'hfff0, 3'd0, 3'd1, 3'd2, 0, "R6 masked");
        run_op(2'b01, 0, {112'h0, 16'h8000}, {112'h0, 16'h8000}, 128'h0, 16'h0001, 3'd0, 3'd1, 3'd2, 0, "R6 active");
        // R7: clear and saturation in the same cycle keeps it set, clear alone clears
        run_op(2'b10, 1, {4{32'h8000_0000}}, {4{32'h8000_0000}}, 128'h0, 16'h0100, 3'd0, 3'd1, 3'd2, 1, "R7 clr+set");
        run_op(2'b01, 0, 128'h3, 128'h5, 128'h0, 16'hffff, 3'd0, 3'd1, 3'd2, 1, "R7 clr");

        // R9: idle cycle holds the result
        @(negedge clk);
        @(posedge clk); #1;
        chk(res_valid === 1'b0, "R9 idle valid", 128'(res_valid), 128'd0);
        chk(res_vec === exp_vec, "R9 idle hold", res_vec, exp_vec);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule